// File: doc/BRIEF.md
# Option Byte Configuration Loader

After reset is released, this block reads a small set of configuration bytes from a fixed window at the top of program memory. It reads one byte for each instruction-cycle strobe, always in ascending address order. From those bytes it latches the output mode of every port pin, the output level two ports drive after reset, the watchdog enable and the oscillator type. The port pad logic and the clock logic downstream take these latched values.

Until the last byte is taken, the loader holds every port configuration bit at the open-drain code and the remaining option outputs low. This keeps the pins in a known, harmless state during the load. When the last byte is latched, a done level rises and stays high. A one-cycle start pulse also fires, and it releases the processor to begin fetching from address zero. Some bits in the window carry no function and must be programmed to zero. Any such bit that reads as one is dropped, and it sets a sticky error flag.

Top module: `opt_loader`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `load_done`, `cpu_start` and `option_error` are 0, `port_cfg` is all zeros, and `wdt_en`, `p0_rst_high`, `p1_rst_high` and `osc_xtal` are 0.
- R2: Before loading completes, `mem_rd` is 1 in exactly those cycles where `cyc_stb` is 1. With `mem_rd` high, `mem_addr` equals 2000H plus the number of bytes already taken, so the reads run 2000H, 2001H, up to 2007H.
- R3: The loader samples `mem_rdata` in each cycle where `mem_rd` is 1. Cycles without a strobe make no progress. `load_done` rises in the cycle after the eighth strobe and then stays 1 until reset.
- R4: While `load_done` is 0, `port_cfg` is all zeros (open-drain) and the four scalar option outputs are 0. Once `load_done` is 1, all of these show the latched values.
- R5: The byte at 2000H sets the scalar options. Bit 0 drives `wdt_en`, bit 1 drives `p0_rst_high`, bit 2 drives `p1_rst_high`, and bit 4 drives `osc_xtal` (1 = ceramic resonator, 0 = RC or external clock).
- R6: The bits of `port_cfg` (1 = push-pull or pull-up, 0 = open-drain) come from the option bytes as follows:
  - [7:0] ← 2001H bits 7:0 (P0 pins 0–3, then P1 pins 0–3)
  - [14:8] ← 2002H bits 6:0 (P2 pins 0–3, then P3 pins 0–2)
  - [22:15] ← 2003H bits 7:0 (P4, then P5)
  - [26:23] ← 2004H bits 3:0 (P6)
  - [28:27] ← 2007H bits 3:2 (PC2, PC3)
- R7: The reserved bits are:
  - 2000H: bits 3, 5, 6 and 7
  - 2002H: bit 7
  - 2004H: bits 7:4
  - 2005H and 2006H: every bit
  - 2007H: bits 1:0 and 7:4

  A reserved bit has no effect on any option output. If one reads as 1 during the load, `option_error` becomes 1 and stays 1 until reset.
- R8: `cpu_start` is high for exactly one cycle, and that cycle is the first cycle in which `load_done` is 1.
- R9: Asserting reset in the middle of a load discards the bytes taken so far. The next load starts again at 2000H.
- R10: After loading completes, strobes cause no read (`mem_rd` stays 0) and every option output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_stb | input | 1 | One-cycle instruction-cycle strobe |
| mem_rd | output | 1 | Read request to program memory |
| mem_addr | output | 14 | Read address |
| mem_rdata | input | 8 | Read data, valid in the cycle `mem_rd` is high |
| port_cfg | output | 29 | Per-pin output mode, 1 = push-pull or pull-up |
| p0_rst_high | output | 1 | P0 output level after reset |
| p1_rst_high | output | 1 | P1 output level after reset |
| wdt_en | output | 1 | Watchdog enable |
| osc_xtal | output | 1 | Oscillator type, 1 = ceramic resonator |
| load_done | output | 1 | Configuration loaded |
| cpu_start | output | 1 | One-cycle release pulse for the processor |
| option_error | output | 1 | Sticky flag: a reserved bit read as 1 |

## Verification
The assertions check several properties on every cycle:
- `load_done` and `option_error` never fall once set.
- `cpu_start` is a single pulse that coincides with the first done cycle.
- Reads stay inside the eight-byte window.
- Outputs are forced low before done and are frozen after it.

Only the bench's scenarios can show that each bit reaches the right field. The same holds for the reserved-bit masks, for how sparse strobes space out the reads, and for the restart from 2000H after a mid-load reset. The bench covers these by running a behavioural model next to the design and comparing the two on every clock.

// File: rtl/opt_pkg.sv
package opt_pkg;

    localparam int OPT_BYTES = 8;
    localparam int IDX_W     = $clog2(OPT_BYTES);

    // port configuration vector layout
    localparam int GRP_A_LO = 0;   // P0, P1  (byte 1)
    localparam int GRP_B_LO = 8;   // P2, P3  (byte 2, 7 bits)
    localparam int GRP_C_LO = 15;  // P4, P5  (byte 3)
    localparam int GRP_D_LO = 23;  // P6      (byte 4, 4 bits)
    localparam int GRP_E_LO = 27;  // PC2/PC3 (byte 7, bits 3:2)
    localparam int CFG_W    = 29;

    typedef struct packed {
        logic wdt_en;
        logic p0_high;
        logic p1_high;
        logic osc_xtal;
    } core_opt_t;

    // bits that carry no function in each option byte
    function automatic logic [7:0] resv_mask(input logic [IDX_W-1:0] k);
        case (k)
            3'd0:    return 8'hE8;
            3'd2:    return 8'h80;
            3'd4:    return 8'hF0;
            3'd5:    return 8'hFF;
            3'd6:    return 8'hFF;
            3'd7:    return 8'hF3;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/opt_seq.sv
module opt_seq
    import opt_pkg::*;
#(
    parameter int               ADDR_W    = 14,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 14'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              load_done,
    output logic              cpu_start
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OPT_BYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             done;
        logic             start;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (cyc_stb && !st_q.done) begin
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == LAST_IDX) begin
                st_d.done  = 1'b1;
                st_d.start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_rd    = cyc_stb & ~st_q.done;
    assign mem_addr  = BASE_ADDR + ADDR_W'(st_q.idx);
    assign cap_idx   = st_q.idx;
    assign load_done = st_q.done;
    assign cpu_start = st_q.start;

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done); // R3
    AST_START_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |-> load_done); // R8
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start |=> !cpu_start); // R8
    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr >= BASE_ADDR && mem_addr < BASE_ADDR + ADDR_W'(OPT_BYTES))); // R2

endmodule

// File: rtl/opt_capture.sv
module opt_capture
    import opt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [7:0]       rdata,
    output core_opt_t        core_opt,
    output logic [CFG_W-1:0] cfg_bits,
    output logic             opt_error
);

    typedef struct packed {
        core_opt_t        core;
        logic [CFG_W-1:0] cfg;
        logic             err;
    } cap_t;

    cap_t cap_q, cap_d;

    always_comb begin
        cap_d = cap_q;
        if (cap_en) begin
            if ((rdata & resv_mask(cap_idx)) != 8'h00)
                cap_d.err = 1'b1;
            case (cap_idx)
                3'd0: begin
                    cap_d.core.wdt_en   = rdata[0];
                    cap_d.core.p0_high  = rdata[1];
                    cap_d.core.p1_high  = rdata[2];
                    cap_d.core.osc_xtal = rdata[4];
                end
                3'd1: cap_d.cfg[GRP_B_LO-1:GRP_A_LO] = rdata;
                3'd2: cap_d.cfg[GRP_C_LO-1:GRP_B_LO] = rdata[6:0];
                3'd3: cap_d.cfg[GRP_D_LO-1:GRP_C_LO] = rdata;
                3'd4: cap_d.cfg[GRP_E_LO-1:GRP_D_LO] = rdata[3:0];
                3'd7: cap_d.cfg[CFG_W-1:GRP_E_LO]    = rdata[3:2];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign core_opt  = cap_q.core;
    assign cfg_bits  = cap_q.cfg;
    assign opt_error = cap_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        opt_error |=> opt_error); // R7

endmodule

// File: rtl/opt_gate.sv
module opt_gate
    import opt_pkg::*;
(
    input  logic             load_done,
    input  core_opt_t        core_opt,
    input  logic [CFG_W-1:0] cfg_bits,
    output logic [CFG_W-1:0] port_cfg,
    output logic             wdt_en,
    output logic             p0_rst_high,
    output logic             p1_rst_high,
    output logic             osc_xtal
);

    always_comb begin
        port_cfg    = '0;
        wdt_en      = 1'b0;
        p0_rst_high = 1'b0;
        p1_rst_high = 1'b0;
        osc_xtal    = 1'b0;
        if (load_done) begin
            port_cfg    = cfg_bits;
            wdt_en      = core_opt.wdt_en;
            p0_rst_high = core_opt.p0_high;
            p1_rst_high = core_opt.p1_high;
            osc_xtal    = core_opt.osc_xtal;
        end
    end

endmodule

// File: rtl/opt_loader.sv
module opt_loader
    import opt_pkg::*;
#(
    parameter int               ADDR_W    = 14,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 14'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [CFG_W-1:0]  port_cfg,
    output logic              p0_rst_high,
    output logic              p1_rst_high,
    output logic              wdt_en,
    output logic              osc_xtal,
    output logic              load_done,
    output logic              cpu_start,
    output logic              option_error
);

    logic [IDX_W-1:0] cap_idx;
    core_opt_t        core_opt;
    logic [CFG_W-1:0] cfg_bits;

    opt_seq #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_stb   (cyc_stb),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .cap_idx   (cap_idx),
        .load_done (load_done),
        .cpu_start (cpu_start)
    );

    opt_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (mem_rd),
        .cap_idx   (cap_idx),
        .rdata     (mem_rdata),
        .core_opt  (core_opt),
        .cfg_bits  (cfg_bits),
        .opt_error (option_error)
    );

    opt_gate u_gate (
        .load_done   (load_done),
        .core_opt    (core_opt),
        .cfg_bits    (cfg_bits),
        .port_cfg    (port_cfg),
        .wdt_en      (wdt_en),
        .p0_rst_high (p0_rst_high),
        .p1_rst_high (p1_rst_high),
        .osc_xtal    (osc_xtal)
    );

    AST_SAFE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (port_cfg == '0 && !wdt_en && !osc_xtal && !p0_rst_high && !p1_rst_high)); // R4
    AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && $past(load_done)) |-> ($stable(port_cfg) && $stable(wdt_en) && $stable(osc_xtal))); // R10

endmodule

// File: tb/opt_loader_test.sv
module opt_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0;
    logic        mem_rd;
    logic [13:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [28:0] port_cfg;
    logic        p0_rst_high, p1_rst_high, wdt_en, osc_xtal;
    logic        load_done, cpu_start, option_error;

    always #5 clk = ~clk;

    opt_loader uut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .port_cfg(port_cfg), .p0_rst_high(p0_rst_high), .p1_rst_high(p1_rst_high),
        .wdt_en(wdt_en), .osc_xtal(osc_xtal), .load_done(load_done),
        .cpu_start(cpu_start), .option_error(option_error)
    );

    // program memory image for the option window
    logic [7:0] img [8];
    assign mem_rdata = (mem_addr >= 14'h2000 && mem_addr < 14'h2008) ? img[mem_addr[2:0]] : 8'h00;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // behavioural reference model
    int         m_cnt;
    bit         m_done, m_start, m_err;
    logic [7:0] m_byte [8];

    function automatic logic [7:0] unused_bits(int k);
        case (k)
            0: return 8'b1110_1000;
            2: return 8'b1000_0000;
            4: return 8'b1111_0000;
            5, 6: return 8'b1111_1111;
            7: return 8'b1111_0011;
            default: return 8'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_start = 0; m_err = 0;
            for (int i = 0; i < 8; i++) m_byte[i] = 8'h00;
        end else begin
            m_start = 0;
            if (cyc_stb && !m_done) begin
                m_byte[m_cnt] = img[m_cnt];
                if ((img[m_cnt] & unused_bits(m_cnt)) != 0) m_err = 1;
                m_cnt++;
                if (m_cnt == 8) begin m_done = 1; m_start = 1; end
            end
        end
    end

    function automatic logic [28:0] exp_cfg();
        logic [28:0] v = '0;
        for (int p = 0; p < 29; p++) begin
            int b, s;
            if (p < 8)       begin b = 1; s = p;      end
            else if (p < 15) begin b = 2; s = p - 8;  end
            else if (p < 23) begin b = 3; s = p - 15; end
            else if (p < 27) begin b = 4; s = p - 23; end
            else             begin b = 7; s = p - 25; end
            v[p] = m_byte[b][s];
        end
        return m_done ? v : '0;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit exp_rd = cyc_stb && !m_done && rst_n;
        chk(mem_rd == exp_rd, m_done ? "R10 no read after done" : "R2 read strobe", 32'(mem_rd), 32'(exp_rd));
        if (exp_rd)
            chk(mem_addr == 14'h2000 + 14'(m_cnt), "R2 read address", 32'(mem_addr), 32'(14'h2000 + m_cnt));
        chk(load_done == m_done, "R3 done", 32'(load_done), 32'(m_done));
        chk(cpu_start == m_start, "R8 start pulse", 32'(cpu_start), 32'(m_start));
        chk(option_error == m_err, "R7 error flag", 32'(option_error), 32'(m_err));
        chk(port_cfg == exp_cfg(), m_done ? "R6 port cfg" : "R4 forced cfg", 32'(port_cfg), 32'(exp_cfg()));
        chk(wdt_en == (m_done & m_byte[0][0]), "R5 watchdog", 32'(wdt_en), 32'(m_done & m_byte[0][0]));
        chk(p0_rst_high == (m_done & m_byte[0][1]), "R5 p0 level", 32'(p0_rst_high), 32'(m_done & m_byte[0][1]));
        chk(p1_rst_high == (m_done & m_byte[0][2]), "R5 p1 level", 32'(p1_rst_high), 32'(m_done & m_byte[0][2]));
        chk(osc_xtal == (m_done & m_byte[0][4]), "R5 oscillator", 32'(osc_xtal), 32'(m_done & m_byte[0][4]));
    endtask

    task automatic tick(bit stb);
        @(negedge clk);
        cyc_stb = stb;
        #1 compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cyc_stb = 0;
        #1;
        chk(!load_done && !cpu_start && !option_error && port_cfg == '0 &&
            !wdt_en && !osc_xtal && !p0_rst_high && !p1_rst_high,
            "R1 reset state", 32'({load_done, cpu_start, option_error}), 32'd0);
        tick(0);
        @(negedge clk);
        rst_n = 1;
        #1 compare_all();
    endtask

    task automatic load_image(logic [7:0] a0, logic [7:0] a1, logic [7:0] a2, logic [7:0] a3,
                              logic [7:0] a4, logic [7:0] a5, logic [7:0] a6, logic [7:0] a7);
        img[0] = a0; img[1] = a1; img[2] = a2; img[3] = a3;
        img[4] = a4; img[5] = a5; img[6] = a6; img[7] = a7;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // image 1: every valid bit set, no reserved bits
        load_image(8'h17, 8'hFF, 8'h7F, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h0C);
        do_reset();
        for (int i = 0; i < 4; i++) tick(0);          // R3 no progress without strobe
        for (int i = 0; i < 8; i++) tick(1);
        for (int i = 0; i < 4; i++) tick(1);          // R10 strobes after done
        chk(load_done && port_cfg == 29'h1FFF_FFFF, "R6 all pins set", 32'(port_cfg), 32'h1FFF_FFFF);

        // image 2: reserved bits set, sparse strobes
        load_image(8'hEA, 8'hA5, 8'hC3, 8'h5A, 8'hF9, 8'h01, 8'h80, 8'hF7);
        do_reset();
        for (int i = 0; i < 8; i++) begin tick(1); tick(0); tick(0); end
        for (int i = 0; i < 3; i++) tick(0);
        chk(option_error == 1'b1, "R7 reserved seen", 32'(option_error), 32'd1);

        // image 3: reset mid-load, then restart with a clean image
        load_image(8'h19, 8'h3C, 8'h55, 8'h81, 8'h06, 8'h00, 8'h00, 8'h08);
        do_reset();
        for (int i = 0; i < 4; i++) tick(1);
        load_image(8'h02, 8'hC0, 8'h2A, 8'h18, 8'h09, 8'h00, 8'h00, 8'h04);
        do_reset();
        @(negedge clk); cyc_stb = 1;
        #1 chk(mem_addr == 14'h2000, "R9 restart address", 32'(mem_addr), 32'h2000);
        compare_all();
        for (int i = 0; i < 7; i++) tick(i % 2 == 0);
        for (int i = 0; i < 10; i++) tick(1);
        chk(option_error == 1'b0, "R9 clean reload", 32'(option_error), 32'd0);

        summary();
    end

endmodule